// File: doc/BRIEF.md
# Sequential Shift-Add Symmetric FIR Filter

This block is a 16-tap FIR filter with fixed integer coefficients that produces one output by visiting one tap per clock cycle. It contains no multiplier. Every tap product is built from a small set of base multiples of the selected sample (zero, one, three and nineteen times the sample, each formed by shifts and adds). A per-tap control word picks the base multiple, a left-shift amount and an optional two's-complement negation. The resulting term is added into a signed accumulator that is wide enough never to wrap.

Samples enter a 16-entry delay line while the filter is idle. A start strobe clears the accumulator and starts a fixed 16-step walk over the taps, from the newest sample at tap 0 to the oldest at tap 15. A one-cycle done pulse marks the finished result, and that result stays on the output until the next start is accepted. The coefficients from tap 0 to tap 15 are 3, 6, 0, -16, -19, 12, 76, 128, 128, 76, 12, -19, -16, 0, 6, 3. The set is mirror-symmetric, so the control word for tap k is also used for tap 15-k.

Top module: `fir_ss_top`

## Requirements
- R1: After a run, out_y equals the sum over k = 0..15 of c[k]·x[k]. Here c is the coefficient list above and x[k] is the sample accepted k samples before the most recent one (tap 0 = newest).
- R2: Tap k and tap 15-k contribute with the same coefficient, so an impulse at tap k and an impulse at tap 15-k give equal outputs.
- R3: A sample is accepted when in_valid is high on a clock edge while no run is in progress. Each accepted sample moves every older sample one tap further along.
- R4: in_valid is ignored while a run is in progress, and the delay line keeps its contents.
- R5: An accepted start clears the accumulator, so each result depends only on the delay line and not on the previous output.
- R6: out_done is high for exactly one cycle, 17 clock cycles after the cycle in which the start was accepted. The zero coefficients do not shorten this.
- R7: Between the done pulse and the next accepted start, out_y holds its value.
- R8: start is ignored while a run is in progress. It neither restarts the walk nor moves the done pulse.
- R9: out_y is a 19-bit two's-complement value. Results at both extremes of the 8-bit signed input range, +66110 and -66490, come out exactly.
- R10: After reset, out_y is 0, out_done is low and the delay line holds zeros, so a run started before any sample arrives gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_sample | input | 8 | Signed input sample |
| in_valid | input | 1 | Offers in_sample for the delay line |
| start | input | 1 | Requests a new output computation |
| out_y | output | 19 | Signed filter result |
| out_done | output | 1 | One-cycle pulse when out_y is final |

## Verification
A unit impulse is walked through all sixteen taps. Each result isolates one coefficient, so a wrong base multiple, shift or sign on any tap shows up. Comparing mirrored positions then tests the symmetric folding. A ramp of distinct values checks tap ordering and accumulation together, because a swapped tap or a stale sample changes the sum. Sign-matched extreme inputs reach the largest positive and negative results, which would expose a short accumulator. A run that receives a stray sample and a second start mid-walk, followed by a repeated start with no new sample, distinguishes correct busy-time rejection and accumulator clearing from designs that accept, restart or keep summing.

// File: rtl/fir_ss_pkg.sv
package fir_ss_pkg;

  localparam int TAPS  = 16;
  localparam int HALF  = TAPS / 2;
  localparam int TAP_W = $clog2(TAPS);
  localparam int SH_W  = 3;

  typedef enum logic [1:0] {
    BASE_ZERO     = 2'd0,
    BASE_ONE      = 2'd1,
    BASE_THREE    = 2'd2,
    BASE_NINETEEN = 2'd3
  } base_sel_e;

  typedef struct packed {
    base_sel_e       base;
    logic [SH_W-1:0] shamt;
    logic            neg;
  } step_ctrl_t;

  // control word for one tap; mirrored taps fold onto the same entry
  function automatic step_ctrl_t ctrl_word(input logic [TAP_W-1:0] tap);
    step_ctrl_t c;
    logic [TAP_W-1:0] j;
    j = (int'(tap) < HALF) ? tap : TAP_W'(TAPS - 1 - int'(tap));
    c = '{base: BASE_ZERO, shamt: '0, neg: 1'b0};
    case (j)
      4'd0: c = '{base: BASE_THREE,    shamt: 3'd0, neg: 1'b0}; //   3
      4'd1: c = '{base: BASE_THREE,    shamt: 3'd1, neg: 1'b0}; //   6
      4'd2: c = '{base: BASE_ZERO,     shamt: 3'd0, neg: 1'b0}; //   0
      4'd3: c = '{base: BASE_ONE,      shamt: 3'd4, neg: 1'b1}; // -16
      4'd4: c = '{base: BASE_NINETEEN, shamt: 3'd0, neg: 1'b1}; // -19
      4'd5: c = '{base: BASE_THREE,    shamt: 3'd2, neg: 1'b0}; //  12
      4'd6: c = '{base: BASE_NINETEEN, shamt: 3'd2, neg: 1'b0}; //  76
      4'd7: c = '{base: BASE_ONE,      shamt: 3'd7, neg: 1'b0}; // 128
      default: c = '{base: BASE_ZERO, shamt: '0, neg: 1'b0};
    endcase
    return c;
  endfunction

  function automatic int base_value(input base_sel_e b);
    case (b)
      BASE_ONE:      return 1;
      BASE_THREE:    return 3;
      BASE_NINETEEN: return 19;
      default:       return 0;
    endcase
  endfunction

  // sum of coefficient magnitudes, used to size the accumulator
  function automatic int coef_abs_sum();
    int s;
    step_ctrl_t c;
    s = 0;
    for (int t = 0; t < TAPS; t++) begin
      c = ctrl_word(TAP_W'(t));
      s += base_value(c.base) << c.shamt;
    end
    return s;
  endfunction

endpackage

// File: rtl/fir_ss_delay_line.sv
module fir_ss_delay_line
  import fir_ss_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = TAPS,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic signed [DATA_W-1:0] din,
  input  logic [SEL_W-1:0]         sel,
  output logic signed [DATA_W-1:0] dout
);

  logic [DEPTH-1:0][DATA_W-1:0] line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        line[0] <= '0;
    else if (shift_en) line[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        line[i] <= '0;
      else if (shift_en) line[i] <= line[i-1];
    end
  end

  assign dout = line[sel];

  // R4: contents frozen whenever no sample is accepted
  p_line_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(line))
    else $error("delay line changed without an accepted sample");

  // R3: accepted sample lands at tap 0, previous tap 0 moves to tap 1
  p_shift_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (line[0] == $past(din)) && (line[1] == $past(line[0])))
    else $error("delay line shift order broken");

endmodule

// File: rtl/fir_ss_sequencer.sv
module fir_ss_sequencer
  import fir_ss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [TAP_W-1:0] tap_idx,
  output logic             launch,
  output logic             step_en,
  output logic             last_step,
  output logic             done
);

  assign launch    = start && !busy;
  assign step_en   = busy;
  assign last_step = busy && (tap_idx == TAP_W'(TAPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tap_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_step;
      if (launch) begin
        busy    <= 1'b1;
        tap_idx <= '0;
      end else if (busy) begin
        tap_idx <= tap_idx + 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

  // R5: an accepted start begins the walk at tap 0
  p_launch_first_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && (tap_idx == '0))
    else $error("run did not begin at tap 0");

  // R8: mid-run the tap index only advances, whatever start does
  p_walk_advances_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy && (tap_idx == $past(tap_idx) + 1'b1))
    else $error("tap walk disturbed");

  // R6: done lasts a single cycle and arrives with the run finished
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy)
    else $error("done while still busy");

endmodule

// File: rtl/fir_ss_datapath.sv
module fir_ss_datapath
  import fir_ss_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_clr,
  input  logic                     acc_en,
  input  logic signed [DATA_W-1:0] sample,
  input  step_ctrl_t               ctrl,
  output logic signed [ACC_W-1:0]  acc
);

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] base_prod;
  logic signed [ACC_W-1:0] shifted;
  logic signed [ACC_W-1:0] term;

  assign x_ext = {{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample};

  // base multiples from shifts and adds only
  always_comb begin
    case (ctrl.base)
      BASE_ONE:      base_prod = x_ext;
      BASE_THREE:    base_prod = (x_ext <<< 1) + x_ext;
      BASE_NINETEEN: base_prod = (x_ext <<< 4) + (x_ext <<< 1) + x_ext;
      default:       base_prod = '0;
    endcase
  end

  assign shifted = base_prod <<< ctrl.shamt;
  assign term    = ctrl.neg ? -shifted : shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (acc_clr) acc <= '0;
    else if (acc_en)  acc <= acc + term;
  end

  // R5: accumulator starts every run from zero
  p_clear_on_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc == '0))
    else $error("accumulator not cleared");

  // R7: result held while idle
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && !acc_en) |=> $stable(acc))
    else $error("output moved while idle");

  // R9: adding same-signed values never flips the sign
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_clr) |=>
      (($past(acc[ACC_W-1]) != $past(term[ACC_W-1])) ||
       (acc[ACC_W-1] == $past(acc[ACC_W-1]))))
    else $error("accumulator wrapped");

endmodule

// File: rtl/fir_ss_top.sv
module fir_ss_top
  import fir_ss_pkg::*;
#(
  parameter int  DATA_W = 8,
  localparam int ACC_W  = DATA_W + 1 + $clog2(coef_abs_sum())
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic                     in_valid,
  input  logic                     start,
  output logic signed [ACC_W-1:0]  out_y,
  output logic                     out_done
);

  logic             busy;
  logic [TAP_W-1:0] tap_idx;
  logic             launch;
  logic             step_en;
  logic             last_step;
  logic             accept;
  logic signed [DATA_W-1:0] tap_sample;
  step_ctrl_t       ctrl;

  assign accept = in_valid && !busy;
  assign ctrl   = ctrl_word(tap_idx);

  fir_ss_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .tap_idx   (tap_idx),
    .launch    (launch),
    .step_en   (step_en),
    .last_step (last_step),
    .done      (out_done)
  );

  fir_ss_delay_line #(.DATA_W(DATA_W), .DEPTH(TAPS)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (in_sample),
    .sel      (tap_idx),
    .dout     (tap_sample)
  );

  fir_ss_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_clr (launch),
    .acc_en  (step_en),
    .sample  (tap_sample),
    .ctrl    (ctrl),
    .acc     (out_y)
  );

  // R4: a busy filter never takes a sample
  p_no_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept)
    else $error("sample accepted during run");

  // R6: the last step is always followed by done
  p_last_then_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> out_done)
    else $error("done missing after last tap");

endmodule

// File: tb/tb_fir_ss_top.sv
module tb_fir_ss_top;

  localparam int YW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [7:0] in_sample = '0;
  logic in_valid = 1'b0;
  logic start = 1'b0;
  logic signed [YW-1:0] out_y;
  logic out_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int coef [16] = '{3, 6, 0, -16, -19, 12, 76, 128, 128, 76, 12, -19, -16, 0, 6, 3};
  int model [16];
  int exp_q [$];
  int last_seen = 0;
  int imp_res [16];

  always #5 clk = ~clk;

  fir_ss_top dut (
    .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .in_valid(in_valid),
    .start(start), .out_y(out_y), .out_done(out_done)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int model_out();
    int s = 0;
    for (int k = 0; k < 16; k++) s += coef[k] * model[k];
    return s;
  endfunction

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (rst_n && out_done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected done", int'(out_y), 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(out_y) == e, "R1 result", int'(out_y), e);
        last_seen = int'(out_y);
      end
    end
  end

  task automatic push_sample(input int v);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 8'(v);
    @(negedge clk);
    in_valid  = 1'b0;
    for (int k = 15; k > 0; k--) model[k] = model[k-1];
    model[0] = v;
  endtask

  // driver: starts a run, queues the expected value, checks R6 latency
  task automatic run(input bit inject);
    bit seen = 1'b0;
    @(negedge clk);
    start = 1'b1;
    exp_q.push_back(model_out());
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (inject && k == 6) begin
        in_valid = 1'b1; in_sample = 8'sd99; start = 1'b1;   // R4, R8 stimulus
      end
      if (inject && k == 7) begin
        in_valid = 1'b0; start = 1'b0;
      end
      if (out_done) begin
        check(k == 17, "R6 done latency", k, 17);
        seen = 1'b1;
        break;
      end
    end
    if (!seen) check(1'b0, "R6 done missing", 0, 1);
    @(negedge clk);
    check(out_done == 1'b0, "R6 done one cycle", int'(out_done), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    check(int'(out_y) == 0, "R10 reset out_y", int'(out_y), 0);
    check(out_done == 1'b0, "R10 reset done", int'(out_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: empty line gives zero
    run(1'b0);

    // R1, R2: impulse walked across every tap
    push_sample(1);
    run(1'b0);
    imp_res[0] = last_seen;
    for (int k = 1; k < 16; k++) begin
      push_sample(0);
      run(1'b0);
      imp_res[k] = last_seen;
    end
    for (int k = 0; k < 8; k++)
      check(imp_res[k] == imp_res[15-k], "R2 mirror taps", imp_res[k], imp_res[15-k]);

    // R3: ramp of distinct values checks ordering
    for (int k = 0; k < 16; k++) push_sample(k * 7 - 50);
    run(1'b0);

    // R9: extreme positive result 66110
    for (int k = 15; k >= 0; k--) push_sample(coef[k] < 0 ? -128 : 127);
    run(1'b0);
    check(last_seen == 66110, "R9 max result", last_seen, 66110);

    // R9: extreme negative result -66490
    for (int k = 15; k >= 0; k--) push_sample(coef[k] < 0 ? 127 : -128);
    run(1'b0);
    check(last_seen == -66490, "R9 min result", last_seen, -66490);

    // R4, R8: sample and start during a run are ignored
    push_sample(5);
    run(1'b1);
    run(1'b0);   // result reveals whether 99 entered the line

    // R5: repeated start with unchanged line gives same value, not a sum
    run(1'b0);

    // R7: output held after done
    repeat (6) @(negedge clk);
    check(int'(out_y) == model_out(), "R7 hold out_y", int'(out_y), model_out());
    check(out_done == 1'b0, "R7 done stays low", int'(out_done), 0);
    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule